// File: doc/BRIEF.md
# Bus Master Read Data Assembler

This block runs the read data phase of a bus master read. After user logic requests a burst of N 32-bit words, the block waits for the command/address phase to finish, which it sees as the address-enable strobe going high. It then pulls data from the read FIFO with an active-low read strobe. The strobe is driven only while the FIFO reports that it holds data.

The path width is chosen per burst. In wide mode each accepted beat is a full 32-bit word. In narrow mode each word arrives as two 16-bit beats, low half first. The block puts the halves together and releases the word only after the high half has been taken. Each completed word goes to user logic with a valid flag, and the word that closes the burst also carries a last flag.

The FIFO marks the closing beat with an active-low last-cycle flag. In narrow mode that beat is the high half of the final word. The block counts the words it delivers against the requested length. When the flag arrives too early, arrives too late or is missing, the block raises a one-cycle length error. It stops the burst when the flag arrives or when the requested count is reached, whichever comes first.

Top module: `mrd_assembler`

## Requirements
- R1: After reset, `busy`, `out_valid`, `out_last` and `len_err` are 0 and `rd_en_n` is 1.
- R2: After an accepted `start`, `rd_en_n` stays 1 while `addr_en_n` is 0. The data phase begins on the clock edge that samples `addr_en_n` high.
- R3: During the data phase, `rd_en_n` is 0 in exactly the cycles where `fifo_nempty` is 1. Each such cycle consumes one beat at the next rising edge. No beat is consumed while `fifo_nempty` is 0.
- R4: In wide mode (`req_narrow`=0 at start), each beat is the whole word on `rdata_wide`, and `fifo_sel` is 0 for the whole burst.
- R5: In narrow mode (`req_narrow`=1 at start), `fifo_sel` is 1 for the whole burst. Beats on `rdata_half` alternate low half, then high half. The delivered word is {high, low}, and a low-half beat alone delivers nothing.
- R6: A word is delivered on `out_data` with `out_valid`=1 for one cycle, in the cycle after the edge that consumes its final beat. Words come out in FIFO order.
- R7: When `last_n` is 0 on a word's final beat, the burst ends. That word carries `out_last`=1, and `busy` falls in the same cycle as the word appears.
- R8: If `last_n` is 0 on the final beat of a word other than word N-1, `len_err` pulses together with that word. If word N-1 completes with `last_n` high, the burst still ends with `out_last` on that word, and `len_err` pulses with it.
- R9: In narrow mode, `last_n`=0 on a low-half beat ends the burst with no word for that beat, no `out_last`, and a `len_err` pulse one cycle later.
- R10: `start` is ignored while `busy` is 1 or when `req_len` is 0. `req_len` and `req_narrow` are sampled only when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse for a new read burst |
| req_len | input | LEN_W | Number of 32-bit words requested (nonzero) |
| req_narrow | input | 1 | 1 selects the 16-bit path for the burst |
| addr_en_n | input | 1 | Active-low address-enable strobe; high ends the address phase |
| fifo_nempty | input | 1 | Read FIFO holds data |
| rdata_wide | input | DATA_W | Wide-mode read beat |
| rdata_half | input | DATA_W/2 | Narrow-mode read beat |
| last_n | input | 1 | Active-low mark on the closing beat |
| rd_en_n | output | 1 | Active-low read strobe to the FIFO |
| fifo_sel | output | 1 | FIFO channel select: 0 wide, 1 narrow |
| busy | output | 1 | Burst in progress |
| out_data | output | DATA_W | Assembled word |
| out_valid | output | 1 | `out_data` is a new word |
| out_last | output | 1 | Word closes the burst |
| len_err | output | 1 | Closing mark disagreed with the requested length |

## Verification
The critical coincidence is that delivery of the closing word and the length-error pulse fall in the same cycle. This happens when the last-cycle flag lands on a word other than N-1, or when the flag never arrives and the count closes the burst. The bench sweeps every flag position from the first word to beyond the end, for lengths 1 to 4 and both widths, with FIFO stalls interleaved. It judges each burst by the index of the flagged word, the number of words, and the word count already delivered when the error pulse is seen. A narrow low-half flag checks the other case, where the error comes without any word.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } ph_t;
endpackage

// File: rtl/mrd_seg_packer.sv
module mrd_seg_packer #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              narrow,
  input  logic [DATA_W-1:0] wide_d,
  input  logic [DATA_W/2-1:0] half_d,
  output logic              word_done,
  output logic              hi_phase,
  output logic [DATA_W-1:0] word
);
  localparam int HALF_W = DATA_W / 2;

  logic              hi_q, hi_d;
  logic [HALF_W-1:0] lo_q, lo_d;
  logic              lo_en;

  assign lo_en = take && narrow && !hi_q;

  always_comb begin
    hi_d = hi_q;
    if (clr)                 hi_d = 1'b0;
    else if (take && narrow) hi_d = !hi_q;
    lo_d = lo_en ? half_d : lo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_phase  = hi_q;
  assign word_done = take && (!narrow || hi_q);
  assign word      = narrow ? {half_d, lo_q} : wide_d;

  AST_LO_HELD_UNTIL_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow && hi_q && !take && !clr) |=> ($stable(lo_q) && hi_q)) else $error("lo half lost"); // R5
endmodule

// File: rtl/mrd_burst_track.sv
module mrd_burst_track #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             step,
  output logic             final_word
);
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d;

  always_comb begin
    cnt_d = cnt_q;
    len_d = len_q;
    if (load) begin
      cnt_d = '0;
      len_d = len;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  assign final_word = (cnt_q == len_q - 1'b1);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt_q < len_q)) else $error("word beyond requested length"); // R8
endmodule

// File: rtl/mrd_assembler.sv
module mrd_assembler
  import mrd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LEN_W-1:0]    req_len,
  input  logic                req_narrow,
  input  logic                addr_en_n,
  input  logic                fifo_nempty,
  input  logic [DATA_W-1:0]   rdata_wide,
  input  logic [DATA_W/2-1:0] rdata_half,
  input  logic                last_n,
  output logic                rd_en_n,
  output logic                fifo_sel,
  output logic                busy,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_valid,
  output logic                out_last,
  output logic                len_err
);
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  ph_t ph_q, ph_d;
  logic narrow_q, narrow_d;
  logic start_ok, take, mark, early_lo, fin, mismatch;
  logic word_done, hi_phase, final_word;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] data_q, data_d;
  logic valid_d, last_d, err_d;
  logic valid_q, last_q, err_q;

  assign start_ok = (ph_q == PH_IDLE) && start && (req_len != '0);
  assign take     = (ph_q == PH_DATA) && fifo_nempty;
  assign mark     = take && !last_n;
  assign early_lo = mark && narrow_q && !hi_phase;
  assign fin      = early_lo || (word_done && (mark || final_word));
  assign mismatch = early_lo || (word_done && (mark != final_word));

  mrd_seg_packer #(.DATA_W(DATA_W)) u_packer (
    .clk       (clk),
    .rst_n     (rst_q),
    .clr       (start_ok),
    .take      (take),
    .narrow    (narrow_q),
    .wide_d    (rdata_wide),
    .half_d    (rdata_half),
    .word_done (word_done),
    .hi_phase  (hi_phase),
    .word      (word)
  );

  mrd_burst_track #(.LEN_W(LEN_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_q),
    .load       (start_ok),
    .len        (req_len),
    .step       (word_done),
    .final_word (final_word)
  );

  always_comb begin
    ph_d     = ph_q;
    narrow_d = narrow_q;
    unique case (ph_q)
      PH_IDLE: if (start_ok) begin
                 ph_d     = PH_ADDR;
                 narrow_d = req_narrow;
               end
      PH_ADDR: if (addr_en_n) ph_d = PH_DATA;
      PH_DATA: if (fin) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
    data_d  = word_done ? word : data_q;
    valid_d = word_done;
    last_d  = word_done && fin;
    err_d   = mismatch;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ph_q     <= PH_IDLE;
      narrow_q <= 1'b0;
      data_q   <= '0;
      valid_q  <= 1'b0;
      last_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      narrow_q <= narrow_d;
      data_q   <= data_d;
      valid_q  <= valid_d;
      last_q   <= last_d;
      err_q    <= err_d;
    end
  end

  assign rd_en_n   = !take;
  assign fifo_sel  = (ph_q != PH_IDLE) && narrow_q;
  assign busy      = (ph_q != PH_IDLE);
  assign out_data  = data_q;
  assign out_valid = valid_q;
  assign out_last  = last_q;
  assign len_err   = err_q;

  AST_STROBE_OFF_AT_START: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(busy) |-> rd_en_n) else $error("strobe during address phase"); // R2
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> $past(!rd_en_n)) else $error("word without strobe"); // R6
  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_q)
    out_last |-> (out_valid && !busy)) else $error("stray last flag"); // R7
  AST_ERR_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_q)
    len_err |-> !busy) else $error("error while busy"); // R8
  AST_WIDE_SEL_LOW: assert property (@(posedge clk) disable iff (!rst_q)
    (!rd_en_n && !narrow_q) |-> !fifo_sel) else $error("wide burst on narrow channel"); // R4
endmodule

// File: tb/mrd_assembler_bench.sv
`timescale 1ns/1ps
module mrd_assembler_bench;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 8;

  logic clk, rst_n;
  logic start, req_narrow, addr_en_n, fifo_nempty, last_n;
  logic [LEN_W-1:0]    req_len;
  logic [DATA_W-1:0]   rdata_wide;
  logic [DATA_W/2-1:0] rdata_half;
  logic rd_en_n, fifo_sel, busy, out_valid, out_last, len_err;
  logic [DATA_W-1:0] out_data;

  mrd_assembler #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_mrd_assembler (
    .clk(clk), .rst_n(rst_n), .start(start), .req_len(req_len),
    .req_narrow(req_narrow), .addr_en_n(addr_en_n), .fifo_nempty(fifo_nempty),
    .rdata_wide(rdata_wide), .rdata_half(rdata_half), .last_n(last_n),
    .rd_en_n(rd_en_n), .fifo_sel(fifo_sel), .busy(busy), .out_data(out_data),
    .out_valid(out_valid), .out_last(out_last), .len_err(len_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // output monitor
  int got_n, last_idx, last_cnt, err_cnt, err_at;
  logic [DATA_W-1:0] got_d [0:15];
  bit mon_clr;
  always @(negedge clk) begin
    if (mon_clr) begin
      got_n = 0; last_idx = -1; last_cnt = 0; err_cnt = 0; err_at = -1;
    end else begin
      if (out_valid) begin
        if (got_n < 16) got_d[got_n] = out_data;
        if (out_last) begin last_idx = got_n; last_cnt++; end
        got_n++;
      end
      if (len_err) begin err_cnt++; err_at = got_n; end
    end
  end

  function automatic logic [31:0] wval(input int b, input int i);
    logic [31:0] v;
    v = {8'(b + 1), 8'(i * 37 + 5), 16'(b * 1009 + i * 7919)};
    return v ^ 32'h5A3C_96E1;
  endfunction

  task automatic run_burst(input int b, input bit nar, input int len, input int lat,
                           input int lo_k, input int seed, input int addr_d, input bit poke);
    int sp, last_seg, end_seg, nexp, exp_last, idx, cyc;
    bit exp_err, ne;
    logic [31:0] w;
    sp = nar ? 2 : 1;
    if (lo_k >= 0) begin
      last_seg = 2 * lo_k; end_seg = last_seg; nexp = lo_k; exp_last = -1; exp_err = 1;
    end else if (lat >= 0 && lat < len) begin
      last_seg = lat * sp + sp - 1; end_seg = last_seg; nexp = lat + 1;
      exp_last = lat; exp_err = (lat != len - 1);
    end else begin
      last_seg = -1; end_seg = len * sp - 1; nexp = len; exp_last = len - 1; exp_err = 1;
    end

    @(negedge clk);
    mon_clr = 1;
    start = 1; req_len = LEN_W'(len); req_narrow = nar;
    addr_en_n = 0; fifo_nempty = 1; last_n = 0;
    @(negedge clk);
    mon_clr = 0;
    start = 0; req_narrow = !nar; req_len = 8'd9;
    #1;
    check(busy === 1'b1, "R10 start accepted", busy, 1);
    check(rd_en_n === 1'b1, "R2 strobe held in address phase", rd_en_n, 1);
    for (int k = 0; k < addr_d; k++) begin
      @(negedge clk); #1;
      check(rd_en_n === 1'b1, "R2 strobe held while addr_en_n low", rd_en_n, 1);
    end
    @(negedge clk);
    addr_en_n = 1;
    #1;
    check(rd_en_n === 1'b1, "R2 no strobe before phase edge", rd_en_n, 1);

    idx = 0; cyc = 0;
    while (idx <= end_seg && cyc < 200) begin
      @(negedge clk);
      ne = (seed == 0) || (((cyc + seed) % 3) != 0);
      fifo_nempty = ne;
      w = wval(b, idx / sp);
      rdata_wide = nar ? ~w : w;
      rdata_half = nar ? ((idx % 2 == 0) ? w[15:0] : w[31:16]) : ~w[15:0];
      last_n = !(ne && idx == last_seg);
      start = poke && (cyc == 2);
      req_len = 8'd1;
      #1;
      check(rd_en_n === !ne, "R3 strobe follows not-empty", rd_en_n, !ne);
      check(fifo_sel === nar, nar ? "R5 narrow select" : "R4 wide select", fifo_sel, nar);
      if (ne) idx++;
      cyc++;
    end
    @(negedge clk);
    fifo_nempty = 0; start = 0; last_n = 0;
    repeat (3) @(negedge clk);
    #1;
    check(busy === 1'b0, "R7 burst ended", busy, 0);
    check(rd_en_n === 1'b1, "R3 strobe idle after burst", rd_en_n, 1);
    check(got_n == nexp, nar ? "R5 word count" : "R6 word count", got_n, nexp);
    for (int i = 0; i < nexp && i < got_n && i < 16; i++)
      check(got_d[i] === wval(b, i), nar ? "R5 assembled word" : "R4 wide word",
            got_d[i], wval(b, i));
    if (lo_k >= 0) begin
      check(last_cnt == 0, "R9 no last flag", last_cnt, 0);
      check(err_cnt == 1 && err_at == nexp, "R9 error without word", err_at, nexp);
    end else begin
      check(last_cnt == 1 && last_idx == exp_last, "R7 last flag position", last_idx, exp_last);
      check(err_cnt == int'(exp_err), "R8 length error count", err_cnt, exp_err);
      if (exp_err) check(err_at == nexp, "R8 error with closing word", err_at, nexp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int b;
    rst_n = 0; start = 0; req_len = '0; req_narrow = 0; addr_en_n = 0;
    fifo_nempty = 0; rdata_wide = '0; rdata_half = '0; last_n = 1; mon_clr = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    check(busy === 1'b0, "R1 busy after reset", busy, 0);
    check(rd_en_n === 1'b1, "R1 strobe after reset", rd_en_n, 1);
    check(out_valid === 1'b0 && out_last === 1'b0, "R1 outputs after reset", out_valid, 0);
    check(len_err === 1'b0, "R1 error after reset", len_err, 0);

    // zero length start is ignored
    @(negedge clk);
    start = 1; req_len = '0; addr_en_n = 1; fifo_nempty = 1;
    @(negedge clk);
    start = 0;
    repeat (2) begin
      @(negedge clk); #1;
      check(busy === 1'b0, "R10 zero length ignored", busy, 0);
      check(rd_en_n === 1'b1, "R10 no strobe after zero length", rd_en_n, 1);
    end

    b = 0;
    for (int nar = 0; nar < 2; nar++)
      for (int len = 1; len <= 4; len++)
        for (int lat = -1; lat < len; lat++) begin
          run_burst(b, nar[0], len, lat, -1, b % 3, b % 3, (b % 4) == 1);
          b++;
        end
    for (int k = 0; k < 3; k++) begin
      run_burst(b, 1'b1, 3, -1, k, (k + 1) % 3, 1, 1'b0);
      b++;
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule